// File: doc/BRIEF.md
# Port-to-Port Mailbox Interrupt Unit

This block gives the two ports of a shared memory a way to signal each other. Each side has one interrupt flag. The flag is raised when the opposite side writes a fixed mailbox word near the top of the address space. It is cleared when the owning side reads that same word. The unit watches the decoded access strobes, the address and the busy state of each port. It drives one active-low interrupt line per side. The mailbox words are still ordinary memory locations, and the storage array is not part of this unit.

The right-side flag uses the highest address. The left-side flag uses the address one below it. An access only counts if all of these hold:
- the port's chip select is low;
- its semaphore select is high, so this is a normal memory access;
- its busy input is high.

The flags are registered. A qualifying access is sampled on a clock edge, and the interrupt line shows the new value from that edge onward. All control inputs carry plain levels. There is no handshake, because no data moves through the unit.

Top module: `mbx_irq_top`

## Requirements
- R1: While reset is held, and in the first cycle after it, both `l_irq_n` and `r_irq_n` are high.
- R2: A qualified left write to address 2^ADDR_W-1 (0x1FFF by default) drives `r_irq_n` low after the sampling edge. A write means `l_we_n` low.
- R3: A qualified right read of address 2^ADDR_W-1 returns `r_irq_n` high after the sampling edge. A read means `r_we_n` high and `r_oe_n` low.
- R4: A qualified right write to address 2^ADDR_W-2 (0x1FFE by default) drives `l_irq_n` low after the sampling edge.
- R5: A qualified left read of address 2^ADDR_W-2, with `l_oe_n` low, returns `l_irq_n` high after the sampling edge.
- R6: If the busy input of the acting port is low, its set or clear access leaves the flag unchanged.
- R7: An access with chip select high, or with semaphore select low, neither sets nor clears a flag.
- R8: If a set and a clear of the same flag are sampled in the same cycle, the flag ends up set.
- R9: None of the following change a flag:
  - a read with output enable high;
  - a write to the side's own clear address;
  - a read on the setting side;
  - an access to any other address.
- R10: With no qualifying access, each interrupt line holds its value from cycle to cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_cs_n | input | 1 | Left chip select, active low |
| l_we_n | input | 1 | Left write strobe, low = write, high = read |
| l_oe_n | input | 1 | Left output enable, active low |
| l_sem_n | input | 1 | Left semaphore select, must be high for a memory access |
| l_busy_n | input | 1 | Left busy state, low blocks the access |
| l_addr | input | ADDR_W | Left address |
| r_cs_n | input | 1 | Right chip select, active low |
| r_we_n | input | 1 | Right write strobe, low = write, high = read |
| r_oe_n | input | 1 | Right output enable, active low |
| r_sem_n | input | 1 | Right semaphore select, must be high for a memory access |
| r_busy_n | input | 1 | Right busy state, low blocks the access |
| r_addr | input | ADDR_W | Right address |
| l_irq_n | output | 1 | Left interrupt, active low |
| r_irq_n | output | 1 | Right interrupt, active low |

## Verification
The assertions check several rules on every clock:
- a qualified mailbox write sets the target line in the next cycle;
- a set beats a simultaneous clear;
- a lone clear releases the line;
- a busy acting port, or a semaphore access on both sides, leaves the lines stable.

Only the bench's scenarios can show the rest: the reset value, that the wrong strobe combinations and foreign addresses are ignored, and that a flag stays set across long idle stretches until the right port reads it. Those scenarios run against a behavioural model that is compared on every cycle.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic {SIDE_L = 1'b0, SIDE_R = 1'b1} side_e;
  localparam int NUM_SIDES = 2;
  typedef struct packed {
    logic set;
    logic clr;
  } flag_ctl_t;
endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode #(
  parameter int ADDR_W = 13,
  parameter logic [ADDR_W-1:0] WR_ADDR = '1,
  parameter logic [ADDR_W-1:0] RD_ADDR = '1
) (
  input  logic              cs_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              sem_n,
  input  logic              busy_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              wr_hit,
  output logic              rd_hit
);
  logic mem_sel;

  always_comb begin
    mem_sel = !cs_n && sem_n && busy_n;
    wr_hit  = mem_sel && !we_n && (addr == WR_ADDR);
    rd_hit  = mem_sel && we_n && !oe_n && (addr == RD_ADDR);
  end
endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
  input  logic clk,
  input  logic rst_n,
  input  mbx_pkg::flag_ctl_t ctl,
  output logic irq_n
);
  logic pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pending <= 1'b0;
    else if (ctl.set)  pending <= 1'b1;
    else if (ctl.clr)  pending <= 1'b0;
  end

  assign irq_n = ~pending;

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.set |=> !irq_n);
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.clr && !ctl.set) |=> irq_n);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.set && !ctl.clr) |=> $stable(irq_n));
endmodule

// File: rtl/mbx_irq_top.sv
module mbx_irq_top #(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_cs_n,
  input  logic              l_we_n,
  input  logic              l_oe_n,
  input  logic              l_sem_n,
  input  logic              l_busy_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              r_cs_n,
  input  logic              r_we_n,
  input  logic              r_oe_n,
  input  logic              r_sem_n,
  input  logic              r_busy_n,
  input  logic [ADDR_W-1:0] r_addr,
  output logic              l_irq_n,
  output logic              r_irq_n
);
  import mbx_pkg::*;

  localparam logic [ADDR_W-1:0] BOX_R = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] BOX_L = BOX_R - 1'b1;

  logic              cs_n   [NUM_SIDES];
  logic              we_n   [NUM_SIDES];
  logic              oe_n   [NUM_SIDES];
  logic              sem_n  [NUM_SIDES];
  logic              busy_n [NUM_SIDES];
  logic [ADDR_W-1:0] addr   [NUM_SIDES];
  logic              wr_hit [NUM_SIDES];
  logic              rd_hit [NUM_SIDES];
  logic              irq_n  [NUM_SIDES];
  flag_ctl_t         ctl    [NUM_SIDES];

  always_comb begin
    cs_n[SIDE_L]   = l_cs_n;   cs_n[SIDE_R]   = r_cs_n;
    we_n[SIDE_L]   = l_we_n;   we_n[SIDE_R]   = r_we_n;
    oe_n[SIDE_L]   = l_oe_n;   oe_n[SIDE_R]   = r_oe_n;
    sem_n[SIDE_L]  = l_sem_n;  sem_n[SIDE_R]  = r_sem_n;
    busy_n[SIDE_L] = l_busy_n; busy_n[SIDE_R] = r_busy_n;
    addr[SIDE_L]   = l_addr;   addr[SIDE_R]   = r_addr;
  end

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    // A side writes the opposite side's mailbox and reads its own.
    localparam logic [ADDR_W-1:0] OWN_BOX   = (s == 0) ? BOX_L : BOX_R;
    localparam logic [ADDR_W-1:0] OTHER_BOX = (s == 0) ? BOX_R : BOX_L;

    mbx_port_decode #(
      .ADDR_W (ADDR_W),
      .WR_ADDR(OTHER_BOX),
      .RD_ADDR(OWN_BOX)
    ) u_dec (
      .cs_n  (cs_n[s]),
      .we_n  (we_n[s]),
      .oe_n  (oe_n[s]),
      .sem_n (sem_n[s]),
      .busy_n(busy_n[s]),
      .addr  (addr[s]),
      .wr_hit(wr_hit[s]),
      .rd_hit(rd_hit[s])
    );

    always_comb begin
      ctl[s].set = wr_hit[NUM_SIDES-1-s];
      ctl[s].clr = rd_hit[s];
    end

    mbx_flag u_flag (
      .clk  (clk),
      .rst_n(rst_n),
      .ctl  (ctl[s]),
      .irq_n(irq_n[s])
    );
  end

  assign l_irq_n = irq_n[SIDE_L];
  assign r_irq_n = irq_n[SIDE_R];

  logic l_sets_r, r_sets_l;
  assign l_sets_r = !l_cs_n && l_sem_n && l_busy_n && !l_we_n && (l_addr == BOX_R);
  assign r_sets_l = !r_cs_n && r_sem_n && r_busy_n && !r_we_n && (r_addr == BOX_L);

  p_right_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    l_sets_r |=> !r_irq_n);
  p_left_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    r_sets_l |=> !l_irq_n);
  p_right_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!r_busy_n && !l_sets_r) |=> $stable(r_irq_n));
  p_left_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_busy_n && !r_sets_l) |=> $stable(l_irq_n));
  p_sem_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_sem_n && !r_sem_n) |=> ($stable(l_irq_n) && $stable(r_irq_n)));
endmodule

// File: tb/tb_mbx_irq_top.sv
module tb_mbx_irq_top;
  localparam int AW = 13;
  localparam logic [AW-1:0] BOX_R = 13'h1FFF;
  localparam logic [AW-1:0] BOX_L = 13'h1FFE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l_cs_n = 1, l_we_n = 1, l_oe_n = 1, l_sem_n = 1, l_busy_n = 1;
  logic r_cs_n = 1, r_we_n = 1, r_oe_n = 1, r_sem_n = 1, r_busy_n = 1;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic l_irq_n, r_irq_n;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  string cur_req = "R1";
  bit exp_l = 0, exp_r = 0;

  always #10 clk = ~clk;

  mbx_irq_top #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n),
    .l_cs_n(l_cs_n), .l_we_n(l_we_n), .l_oe_n(l_oe_n), .l_sem_n(l_sem_n),
    .l_busy_n(l_busy_n), .l_addr(l_addr),
    .r_cs_n(r_cs_n), .r_we_n(r_we_n), .r_oe_n(r_oe_n), .r_sem_n(r_sem_n),
    .r_busy_n(r_busy_n), .r_addr(r_addr),
    .l_irq_n(l_irq_n), .r_irq_n(r_irq_n)
  );

  // Behavioural reference: pending bits, set beats clear.
  always @(posedge clk) begin
    bit ok_l, ok_r, set_r, clr_r, set_l, clr_l;
    if (!rst_n) begin
      exp_l = 0; exp_r = 0;
    end else begin
      ok_l  = (l_cs_n === 0) && (l_sem_n === 1) && (l_busy_n === 1);
      ok_r  = (r_cs_n === 0) && (r_sem_n === 1) && (r_busy_n === 1);
      set_r = ok_l && l_we_n === 0 && l_addr === BOX_R;
      clr_r = ok_r && r_we_n === 1 && r_oe_n === 0 && r_addr === BOX_R;
      set_l = ok_r && r_we_n === 0 && r_addr === BOX_L;
      clr_l = ok_l && l_we_n === 1 && l_oe_n === 0 && l_addr === BOX_L;
      if (set_r) exp_r = 1; else if (clr_r) exp_r = 0;
      if (set_l) exp_l = 1; else if (clr_l) exp_l = 0;
    end
  end

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model.
  always @(negedge clk) begin
    if (!done) begin
      check({cur_req, " model left"}, l_irq_n, ~exp_l);
      check({cur_req, " model right"}, r_irq_n, ~exp_r);
    end
  end

  task automatic idle();
    l_cs_n = 1; l_we_n = 1; l_oe_n = 1; l_sem_n = 1; l_busy_n = 1; l_addr = '0;
    r_cs_n = 1; r_we_n = 1; r_oe_n = 1; r_sem_n = 1; r_busy_n = 1; r_addr = '0;
  endtask

  task automatic drv_l(logic cs, logic we, logic oe, logic sem, logic busy, logic [AW-1:0] a);
    l_cs_n = cs; l_we_n = we; l_oe_n = oe; l_sem_n = sem; l_busy_n = busy; l_addr = a;
  endtask

  task automatic drv_r(logic cs, logic we, logic oe, logic sem, logic busy, logic [AW-1:0] a);
    r_cs_n = cs; r_we_n = we; r_oe_n = oe; r_sem_n = sem; r_busy_n = busy; r_addr = a;
  endtask

  // Hold the driven access for one edge, then return to idle and land past the edge.
  task automatic fire();
    @(negedge clk);
    idle();
  endtask

  task automatic finish_run();
    done = 1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(20 * 5000);
    fails++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    check("R1 reset left", l_irq_n, 1'b1);
    check("R1 reset right", r_irq_n, 1'b1);
    rst_n = 1;
    @(negedge clk);
    check("R1 after reset left", l_irq_n, 1'b1);
    check("R1 after reset right", r_irq_n, 1'b1);

    cur_req = "R2";
    drv_l(0, 0, 1, 1, 1, BOX_R); fire();
    check("R2 right raised", r_irq_n, 1'b0);
    check("R2 left untouched", l_irq_n, 1'b1);

    cur_req = "R9";
    drv_r(0, 1, 1, 1, 1, BOX_R); fire();
    check("R9 read oe high keeps right", r_irq_n, 1'b0);
    drv_l(0, 1, 0, 1, 1, BOX_R); fire();
    check("R9 left read of right box", r_irq_n, 1'b0);
    drv_r(0, 0, 1, 1, 1, BOX_R); fire();
    check("R9 right write own box", l_irq_n, 1'b1);
    check("R9 right write own box keeps right", r_irq_n, 1'b0);
    drv_r(0, 1, 0, 1, 1, 13'h0123); fire();
    check("R9 other address", r_irq_n, 1'b0);

    cur_req = "R6";
    drv_r(0, 1, 0, 1, 0, BOX_R); fire();
    check("R6 busy blocks clear", r_irq_n, 1'b0);

    cur_req = "R7";
    drv_r(1, 1, 0, 1, 1, BOX_R); fire();
    check("R7 cs high no clear", r_irq_n, 1'b0);
    drv_r(0, 1, 0, 0, 1, BOX_R); fire();
    check("R7 sem access no clear", r_irq_n, 1'b0);

    cur_req = "R10";
    repeat (20) @(negedge clk);
    check("R10 right held", r_irq_n, 1'b0);

    cur_req = "R3";
    drv_r(0, 1, 0, 1, 1, BOX_R); fire();
    check("R3 right cleared", r_irq_n, 1'b1);

    cur_req = "R4";
    drv_r(0, 0, 1, 1, 1, BOX_L); fire();
    check("R4 left raised", l_irq_n, 1'b0);
    check("R4 right untouched", r_irq_n, 1'b1);

    cur_req = "R6";
    drv_l(0, 1, 0, 1, 0, BOX_L); fire();
    check("R6 left busy blocks clear", l_irq_n, 1'b0);
    cur_req = "R9";
    drv_l(0, 0, 0, 1, 1, BOX_L); fire();
    check("R9 left write own box", l_irq_n, 1'b0);

    cur_req = "R5";
    drv_l(0, 1, 0, 1, 1, BOX_L); fire();
    check("R5 left cleared", l_irq_n, 1'b1);

    cur_req = "R6";
    drv_l(0, 0, 1, 1, 0, BOX_R); fire();
    check("R6 busy blocks set", r_irq_n, 1'b1);
    drv_r(0, 0, 1, 1, 0, BOX_L); fire();
    check("R6 busy blocks left set", l_irq_n, 1'b1);
    cur_req = "R7";
    drv_l(1, 0, 1, 1, 1, BOX_R); fire();
    check("R7 cs high no set", r_irq_n, 1'b1);
    drv_l(0, 0, 1, 0, 1, BOX_R); fire();
    check("R7 sem no set", r_irq_n, 1'b1);

    cur_req = "R8";
    drv_l(0, 0, 1, 1, 1, BOX_R); drv_r(0, 1, 0, 1, 1, BOX_R); fire();
    check("R8 set wins right from clear", r_irq_n, 1'b0);
    drv_l(0, 0, 1, 1, 1, BOX_R); drv_r(0, 1, 0, 1, 1, BOX_R); fire();
    check("R8 set wins right from set", r_irq_n, 1'b0);
    drv_r(0, 0, 1, 1, 1, BOX_L); drv_l(0, 1, 0, 1, 1, BOX_L); fire();
    check("R8 set wins left", l_irq_n, 1'b0);

    cur_req = "R3";
    drv_r(0, 1, 0, 1, 1, BOX_R); drv_l(0, 1, 0, 1, 1, BOX_L); fire();
    check("R3 both cleared right", r_irq_n, 1'b1);
    check("R5 both cleared left", l_irq_n, 1'b1);

    cur_req = "R1";
    drv_l(0, 0, 1, 1, 1, BOX_R); fire();
    rst_n = 0;
    @(negedge clk);
    check("R1 reset clears right", r_irq_n, 1'b1);
    rst_n = 1;
    @(negedge clk);
    finish_run();
  end
endmodule